// File: doc/BRIEF.md
# Frame Timeslot Bit Inserter

This block places a serial HDLC bit stream into chosen bit positions of an outgoing TDM frame. The framer timing logic supplies a frame count, a timeslot count and a bit count with every bit time. A bit time is marked by `bit_valid`. The block compares these counts with its configuration. When they match, it raises a one-cycle take strobe that pulls the next bit from the HDLC serializer, and it sends that bit on the line in place of the frame bit. Every other bit of the frame passes through unchanged.

The configuration has four parts. Two flags choose even frames, odd frames, or both. A timeslot number chooses one channel of the frame. An 8-bit mask chooses which bits of that channel carry HDLC data. A global enable switches the whole function on or off. Line data is registered once, so `data_out` and `ins_mark` follow the bit time that produced them by one clock.

Top module: `tsbit_inserter`

## Requirements
- R1: After reset `data_out` and `ins_mark` are 0.
- R2: While `enable` is 0, `hdlc_take` stays 0 and every valid bit passes through to `data_out` unchanged.
- R3: Frame parity is taken from bit 0 of `frame_cnt`, and 0 means even. Insertion happens in even frames only when `sel_even` is 1, and in odd frames only when `sel_odd` is 1.
- R4: Insertion happens only in the bit times whose `slot_cnt` equals `slot_sel`.
- R5: Mask bit 7 selects bit count 0, the first bit sent in the slot. Mask bit 0 selects bit count 7, the last bit. In general, mask bit (7 - `bit_cnt`) governs each bit time.
- R6: `hdlc_take` is a combinational strobe that lasts exactly one cycle for each selected bit time. It is never high in a cycle where `bit_valid` is 0.
- R7: In the cycle after a take, `data_out` equals the `hdlc_bit` that was presented with the take, and `ins_mark` is 1.
- R8: In the cycle after a valid bit that is not selected, `data_out` equals that cycle's `data_in`, and `ins_mark` is 0.
- R9: If `slot_sel` is equal to or greater than NUM_SLOTS, nothing is inserted, even when `slot_cnt` matches it.
- R10: In a cycle where `bit_valid` is 0, `data_out` and `ins_mark` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global insertion enable |
| sel_even | input | 1 | Insert in even frames |
| sel_odd | input | 1 | Insert in odd frames |
| slot_sel | input | SLOT_W | Timeslot that carries HDLC data |
| bit_mask | input | 8 | Bit positions used in the slot; bit 7 is the first bit sent |
| bit_valid | input | 1 | Marks a bit time |
| frame_cnt | input | FRAME_W | Frame counter from the framer |
| slot_cnt | input | SLOT_W | Timeslot counter from the framer |
| bit_cnt | input | 3 | Bit counter within the slot; 0 is the first bit sent |
| data_in | input | 1 | Original frame bit |
| hdlc_bit | input | 1 | Next bit from the HDLC serializer |
| hdlc_take | output | 1 | Pulls the serializer bit in this bit time |
| data_out | output | 1 | Outgoing line bit, one clock after its bit time |
| ins_mark | output | 1 | The last output bit came from the serializer |

## Verification
Any wrong decode of parity, slot or mask shows up on `hdlc_take` in the very bit time it occurs. On the next clock it also shows up as a bit on `data_out` that is either replaced or missing. If the output register holds a bad value or misses an update, `data_out` and `ins_mark` are wrong one clock after the affected bit time. The bench scans whole frames under several configurations and compares both the strobe and the delayed line bit at every position. Because of this, a single misplaced bit cannot hide until the end of the frame.

// File: rtl/tsbit_inserter.sv
module tsbit_inserter #(
  parameter int NUM_SLOTS = 24,
  parameter int SLOT_W    = 5,
  parameter int FRAME_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sel_even,
  input  logic               sel_odd,
  input  logic [SLOT_W-1:0]  slot_sel,
  input  logic [7:0]         bit_mask,
  input  logic               bit_valid,
  input  logic [FRAME_W-1:0] frame_cnt,
  input  logic [SLOT_W-1:0]  slot_cnt,
  input  logic [2:0]         bit_cnt,
  input  logic               data_in,
  input  logic               hdlc_bit,
  output logic               hdlc_take,
  output logic               data_out,
  output logic               ins_mark
);
  localparam logic [SLOT_W:0] SLOT_LIMIT = (SLOT_W+1)'(NUM_SLOTS);

  logic parity_ok, slot_ok, mask_ok;

  assign parity_ok = frame_cnt[0] ? sel_odd : sel_even;
  assign slot_ok   = (slot_cnt == slot_sel) && ({1'b0, slot_sel} < SLOT_LIMIT);
  assign mask_ok   = bit_mask[~bit_cnt];
  assign hdlc_take = enable & bit_valid & parity_ok & slot_ok & mask_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= 1'b0;
      ins_mark <= 1'b0;
    end else if (bit_valid) begin
      data_out <= hdlc_take ? hdlc_bit : data_in;
      ins_mark <= hdlc_take;
    end
  end

  a_r6_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hdlc_take |-> bit_valid && enable);
  a_r3_parity: assert property (@(posedge clk) disable iff (!rst_n)
    hdlc_take |-> (frame_cnt[0] ? sel_odd : sel_even));
  a_r9_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, slot_sel} >= SLOT_LIMIT) |-> !hdlc_take);
  a_r7_insert: assert property (@(posedge clk) disable iff (!rst_n)
    hdlc_take |=> ins_mark && data_out == $past(hdlc_bit));
  a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !hdlc_take |=> !ins_mark && data_out == $past(data_in));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(data_out) && $stable(ins_mark));
endmodule

// File: tb/tsbit_inserter_tb.sv
module tsbit_inserter_tb_top;
  localparam int NUM_SLOTS = 24;

  logic clk = 0, rst_n = 0;
  logic enable = 0, sel_even = 0, sel_odd = 0, bit_valid = 0;
  logic [4:0] slot_sel = 0, slot_cnt = 0;
  logic [7:0] bit_mask = 0;
  logic [3:0] frame_cnt = 0;
  logic [2:0] bit_cnt = 0;
  logic data_in = 0, hdlc_bit = 0;
  logic hdlc_take, data_out, ins_mark;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tsbit_inserter #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(5), .FRAME_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sel_even(sel_even), .sel_odd(sel_odd),
    .slot_sel(slot_sel), .bit_mask(bit_mask), .bit_valid(bit_valid), .frame_cnt(frame_cnt),
    .slot_cnt(slot_cnt), .bit_cnt(bit_cnt), .data_in(data_in), .hdlc_bit(hdlc_bit),
    .hdlc_take(hdlc_take), .data_out(data_out), .ins_mark(ins_mark));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (frame %0d slot %0d bit %0d)",
               req, act, exp, frame_cnt, slot_cnt, bit_cnt);
    end
  endtask

  task automatic step(logic v, int f, int s, int b, string req);
    logic exp_hit, din, hb, par;
    @(negedge clk);
    din = ^{f[3:0], s[4:0], b[2:0]} ^ s[1];
    hb = ~din;
    bit_valid = v; frame_cnt = f[3:0]; slot_cnt = s[4:0]; bit_cnt = b[2:0];
    data_in = din; hdlc_bit = hb;
    par = f[0] ? sel_odd : sel_even;
    exp_hit = enable && v && par && (s == int'(slot_sel)) && (int'(slot_sel) < NUM_SLOTS)
              && bit_mask[7-b];
    #1 check({req, " take"}, hdlc_take, exp_hit);
    if (v) begin
      @(negedge clk);
      check(exp_hit ? "R7 data" : "R8 data", data_out, exp_hit ? hb : din);
      check(exp_hit ? "R7 mark" : "R8 mark", ins_mark, exp_hit);
    end
  endtask

  task automatic scan(int nframes, int nslots, string req);
    for (int f = 0; f < nframes; f++)
      for (int s = 0; s < nslots; s++)
        for (int b = 0; b < 8; b++) step(1'b1, f, s, b, req);
  endtask

  task automatic test_reset;
    #1 check("R1 data", data_out, 0);
    check("R1 mark", ins_mark, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic test_disabled;
    enable = 0; sel_even = 1; sel_odd = 1; slot_sel = 5; bit_mask = 8'hFF;
    scan(2, NUM_SLOTS, "R2");
  endtask

  task automatic test_even_only;
    enable = 1; sel_even = 1; sel_odd = 0; slot_sel = 3; bit_mask = 8'b1000_0001;
    scan(4, NUM_SLOTS, "R3 R4 R5 even");
  endtask

  task automatic test_odd_only;
    enable = 1; sel_even = 0; sel_odd = 1; slot_sel = 23; bit_mask = 8'b0110_1000;
    scan(4, NUM_SLOTS, "R3 R5 odd");
  endtask

  task automatic test_both_full;
    enable = 1; sel_even = 1; sel_odd = 1; slot_sel = 0; bit_mask = 8'hFF;
    scan(2, 4, "R4 R6 both");
    bit_mask = 8'h00;
    scan(1, 2, "R5 empty mask");
  endtask

  task automatic test_out_of_range;
    enable = 1; sel_even = 1; sel_odd = 1; slot_sel = 27; bit_mask = 8'hFF;
    scan(2, 32, "R9");
  endtask

  task automatic test_valid_gap;
    logic d0, m0;
    enable = 1; sel_even = 1; sel_odd = 1; slot_sel = 2; bit_mask = 8'hFF;
    step(1'b1, 0, 2, 0, "R6");
    d0 = data_out; m0 = ins_mark;
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 0, 2, k, "R6 no valid");
      @(negedge clk);
      check("R10 data hold", data_out, d0);
      check("R10 mark hold", ins_mark, m0);
    end
    step(1'b1, 0, 2, 1, "R6 resume");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    test_reset();
    test_disabled();
    test_even_only();
    test_odd_only();
    test_both_full();
    test_out_of_range();
    test_valid_gap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule